// File: doc/BRIEF.md
# Dual-Rail Zero-Substitution Line Decoder

This block turns the dual-rail output of a line receiver (one sample per recovered bit on each of a positive and a negative rail) back into NRZ data. A pulse on exactly one rail is a mark and yields a one. No pulse yields a zero. A zero-substitution code inserted by the far-end encoder is found and replaced by zeros. The block also raises a line code violation flag for malformed traffic.

Two substitution rules are supported. With `mode_e3_i` low the three-bit rule for DS3/STS-1 rates applies. With `mode_e3_i` high the four-bit rule for E3 rates applies. A bypass control turns all substitution handling off, which leaves plain alternate-mark-inversion decoding. A four-slot lookahead line holds recent symbols, so a substitution can be recognised on its final pulse and its earlier slots cleared before they leave. Data and flag emerge together with a latency of four cycles in every mode.

Top module: `zsd_line_decoder`

## Requirements
- R1: After reset `nrz_o` and `lcv_o` are 0. The first single-rail pulse after reset is never treated as a violation.
- R2: The bit sampled on rails at clock edge k appears on `nrz_o` and `lcv_o` after edge k+4. A single-rail pulse outside any substitution gives 1. An empty sample gives 0.
- R3: With `mode_e3_i`=0, a violation preceded by two slots of the form (zero or alternating mark, zero) is a legal substitution. All three bits come out as 0 with no flag.
- R4: With `mode_e3_i`=1, a violation preceded by three slots of the form (zero or alternating mark, zero, zero) is a legal substitution. All four bits come out as 0 with no flag.
- R5: A violation that completes no legal substitution is output as 1, and `lcv_o` is 1 on that same output bit.
- R6: `lcv_o` is 1 on every zero bit that brings the current run of consecutive zeros to 3 or more (mode 0) or to 4 or more (mode 1).
- R7: A sample with both rails high is output as 0 and flagged on `lcv_o`. It leaves the polarity reference unchanged. It counts as a zero for run counting and for substitution matching.
- R8: With `dec_bypass_i`=1, `nrz_o` is the XOR of the rails. No substitution is applied, and `lcv_o` is raised only for both-rails samples.
- R9: A violation is a single-rail pulse whose polarity equals that of the previous single-rail pulse. A pulse of opposite polarity is an alternating mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst | input | 1 | Synchronous active-high reset |
| pos_i | input | 1 | Positive-rail pulse sample |
| neg_i | input | 1 | Negative-rail pulse sample |
| mode_e3_i | input | 1 | 0: three-bit substitution rule, 1: four-bit rule |
| dec_bypass_i | input | 1 | 1: plain AMI decoding, substitution and code checks off |
| nrz_o | output | 1 | Decoded data, four cycles behind the rails |
| lcv_o | output | 1 | Line code violation flag, aligned with `nrz_o` |

## Verification
The embedded properties assume that the rails have been sampled for at least five cycles since reset. The bypass property further assumes that the bypass control has been steady over the five-cycle window that a bit spends in the pipeline. The bench changes mode and bypass only while reset is asserted, so every stream runs with fixed settings. The random streams are built from alternating marks, stray violations, both-rail samples, zero runs and legal substitutions chosen for the active rule. Each stream is reset-bounded, so the polarity reference always starts fresh.

// File: rtl/zsd_pkg.sv
`timescale 1ns/1ps
package zsd_pkg;
  // one slot of the lookahead line
  typedef struct packed {
    logic data;  // decoded bit
    logic mark;  // alternating mark still present
    logic lcv;   // violation flag carried with the bit
  } zsd_slot_t;
endpackage

// File: rtl/zsd_symbol_class.sv
`timescale 1ns/1ps
module zsd_symbol_class #(
  parameter int RUN_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pos_i,
  input  logic             neg_i,
  input  logic [RUN_W-1:0] run_len_i,
  input  logic             flag_en_i,
  output logic             pulse_o,
  output logic             mark_o,
  output logic             viol_o,
  output logic             dbl_o,
  output logic             run_lcv_o
);
  logic             seen_q;
  logic             last_pos_q;
  logic [RUN_W-1:0] run_q;
  logic             single_pos;
  logic             single_neg;
  logic [RUN_W:0]   run_inc;

  assign single_pos = pos_i & ~neg_i;
  assign single_neg = neg_i & ~pos_i;
  assign pulse_o    = single_pos | single_neg;
  assign dbl_o      = pos_i & neg_i;
  // same polarity as the last single-rail pulse -> violation (R9)
  assign viol_o     = pulse_o & seen_q & (last_pos_q == single_pos);
  assign mark_o     = pulse_o & ~viol_o;
  assign run_inc    = {1'b0, run_q} + 1'b1;
  assign run_lcv_o  = ~pulse_o & flag_en_i & (run_inc >= {1'b0, run_len_i});

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q     <= 1'b0;
      last_pos_q <= 1'b0;
      run_q      <= '0;
    end else if (pulse_o) begin
      seen_q     <= 1'b1;
      last_pos_q <= single_pos;
      run_q      <= '0;
    end else if (run_q < run_len_i) begin
      run_q <= run_q + 1'b1;
    end
  end

  // two back-to-back opposite single-rail pulses never form a violation
  assert_alternate_no_viol_R9: assert property (@(posedge clk) disable iff (rst)
    (pulse_o && $past(pos_i ^ neg_i) && !$past(rst) && (pos_i != $past(pos_i)))
      |-> !viol_o);
endmodule

// File: rtl/zsd_subst_window.sv
`timescale 1ns/1ps
module zsd_subst_window
  import zsd_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int RUN_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pulse_i,
  input  logic             mark_i,
  input  logic             viol_i,
  input  logic             dbl_i,
  input  logic             run_lcv_i,
  input  logic             subst_en_i,
  input  logic [RUN_W-1:0] sub_len_i,
  output logic             nrz_o,
  output logic             lcv_o
);
  zsd_slot_t sh_q  [DEPTH];
  zsd_slot_t sh_nx [DEPTH];
  logic      match;

  // slot 0 is the newest stored symbol; pattern oldest slot is sub_len-2
  always_comb begin
    match = subst_en_i & viol_i;
    for (int k = 0; k < DEPTH - 1; k++) begin
      if (k < int'(sub_len_i) - 2) begin
        if (sh_q[k].data) match = 1'b0;
      end else if (k == int'(sub_len_i) - 2) begin
        if (sh_q[k].data && !sh_q[k].mark) match = 1'b0;
      end
    end
  end

  always_comb begin
    sh_nx[0].data = pulse_i & ~match;
    sh_nx[0].mark = mark_i & ~match;
    sh_nx[0].lcv  = dbl_i | run_lcv_i | (subst_en_i & viol_i & ~match);
    for (int k = 1; k < DEPTH; k++) begin
      sh_nx[k] = sh_q[k-1];
      if (match && (k - 1 <= int'(sub_len_i) - 2)) begin
        sh_nx[k].data = 1'b0;
        sh_nx[k].mark = 1'b0;
      end
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (rst) sh_q[g] <= '0;
        else     sh_q[g] <= sh_nx[g];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      nrz_o <= 1'b0;
      lcv_o <= 1'b0;
    end else begin
      nrz_o <= sh_q[DEPTH-1].data;
      lcv_o <= sh_q[DEPTH-1].lcv;
    end
  end
endmodule

// File: rtl/zsd_line_decoder.sv
`timescale 1ns/1ps
module zsd_line_decoder #(
  parameter int LAT      = 4,
  parameter int LEN_DS3  = 3,
  parameter int LEN_E3   = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pos_i,
  input  logic neg_i,
  input  logic mode_e3_i,
  input  logic dec_bypass_i,
  output logic nrz_o,
  output logic lcv_o
);
  localparam int RUN_W  = $clog2(LEN_E3 + 1);
  localparam int WARM   = LAT + 1;
  localparam int WARM_W = $clog2(WARM + 1);

  logic             pulse, mark, viol, dbl, run_lcv;
  logic             subst_en;
  logic [RUN_W-1:0] sub_len;
  logic [WARM_W-1:0] warm_q;

  assign subst_en = ~dec_bypass_i;
  assign sub_len  = mode_e3_i ? RUN_W'(LEN_E3) : RUN_W'(LEN_DS3);

  zsd_symbol_class #(.RUN_W(RUN_W)) u_class (
    .clk       (clk),
    .rst       (rst),
    .pos_i     (pos_i),
    .neg_i     (neg_i),
    .run_len_i (sub_len),
    .flag_en_i (subst_en),
    .pulse_o   (pulse),
    .mark_o    (mark),
    .viol_o    (viol),
    .dbl_o     (dbl),
    .run_lcv_o (run_lcv)
  );

  zsd_subst_window #(.DEPTH(LAT), .RUN_W(RUN_W)) u_window (
    .clk        (clk),
    .rst        (rst),
    .pulse_i    (pulse),
    .mark_i     (mark),
    .viol_i     (viol),
    .dbl_i      (dbl),
    .run_lcv_i  (run_lcv),
    .subst_en_i (subst_en),
    .sub_len_i  (sub_len),
    .nrz_o      (nrz_o),
    .lcv_o      (lcv_o)
  );

  // cycles since reset, used only to keep the checks below inside history
  always_ff @(posedge clk) begin
    if (rst)                      warm_q <= '0;
    else if (warm_q != WARM_W'(WARM)) warm_q <= warm_q + 1'b1;
  end

  assert_zero_in_zero_out_R2: assert property (@(posedge clk) disable iff (rst)
    (warm_q == WARM_W'(WARM) && !$past(pos_i ^ neg_i, 5)) |-> !nrz_o);

  assert_double_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (warm_q == WARM_W'(WARM) && $past(pos_i && neg_i, 5)) |-> (lcv_o && !nrz_o));

  assert_bypass_ami_R8: assert property (@(posedge clk) disable iff (rst)
    (warm_q == WARM_W'(WARM) && $past(dec_bypass_i, 5) && $past(dec_bypass_i, 4) &&
     $past(dec_bypass_i, 3) && $past(dec_bypass_i, 2))
      |-> (nrz_o == $past(pos_i ^ neg_i, 5) && lcv_o == $past(pos_i && neg_i, 5)));
endmodule

// File: tb/tb_zsd_line_decoder.sv
`timescale 1ns/1ps
module tb_zsd_line_decoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pos_i = 1'b0, neg_i = 1'b0, mode_e3_i = 1'b0, dec_bypass_i = 1'b0;
  logic nrz_o, lcv_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit sp [0:511];
  bit sn [0:511];
  bit ed [0:511];
  bit em [0:511];
  bit el [0:511];
  int nsym;
  bit gpol;

  always #2 clk = ~clk;

  zsd_line_decoder dut (
    .clk(clk), .rst(rst), .pos_i(pos_i), .neg_i(neg_i),
    .mode_e3_i(mode_e3_i), .dec_bypass_i(dec_bypass_i),
    .nrz_o(nrz_o), .lcv_o(lcv_o)
  );

  // expected stream from the requirements
  task automatic ref_model(input int n, input bit e3, input bit byp);
    int  len = e3 ? 4 : 3;
    bit  seen = 0, lastp = 0;
    int  run = 0;
    for (int i = 0; i < n; i++) begin
      bit p = sp[i] & ~sn[i];
      bit q = sn[i] & ~sp[i];
      bit pulse = p | q;
      bit v = 0;
      if (pulse) begin v = seen && (lastp == p); seen = 1; lastp = p; end
      ed[i] = pulse; em[i] = pulse && !v; el[i] = sp[i] && sn[i];
      if (!pulse) begin
        if (run < len) run++;
        if (!byp && run >= len) el[i] = 1;
      end else run = 0;
      if (pulse && v && !byp) begin
        bit ok = 1;
        for (int k = 1; k <= len - 2; k++)
          if (i - k >= 0 && ed[i-k]) ok = 0;
        if (i - len + 1 >= 0 && ed[i-len+1] && !em[i-len+1]) ok = 0;
        if (ok) begin
          for (int k = 0; k < len; k++)
            if (i - k >= 0) begin ed[i-k] = 0; em[i-k] = 0; end
        end else el[i] = 1;
      end
    end
  endtask

  task automatic put(input bit p, input bit q);
    if (nsym < 400) begin sp[nsym] = p; sn[nsym] = q; nsym++; end
  endtask

  task automatic run_seg(input string tag, input bit e3, input bit byp);
    @(negedge clk);
    rst = 1; pos_i = 0; neg_i = 0; mode_e3_i = e3; dec_bypass_i = byp;
    repeat (3) @(negedge clk);
    checks++;
    if (nrz_o !== 1'b0 || lcv_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset outputs nrz=%0b lcv=%0b expected 0 0", nrz_o, lcv_o);
    end
    ref_model(nsym, e3, byp);
    for (int j = 0; j < nsym + 5; j++) begin
      if (j >= 5) begin
        checks++;
        if (nrz_o !== ed[j-5] || lcv_o !== el[j-5]) begin
          errors++;
          $display("FAIL %s bit %0d nrz=%0b lcv=%0b expected nrz=%0b lcv=%0b",
                   tag, j - 5, nrz_o, lcv_o, ed[j-5], el[j-5]);
        end
      end
      rst = 0;
      pos_i = (j < nsym) ? sp[j] : 1'b0;
      neg_i = (j < nsym) ? sn[j] : 1'b0;
      @(negedge clk);
    end
  endtask

  // symbol helpers for directed streams: 'p','n','0','d'
  task automatic load(input string s);
    nsym = 0;
    foreach (s[i]) begin
      case (s[i])
        "p": put(1, 0);
        "n": put(0, 1);
        "d": put(1, 1);
        default: put(0, 0);
      endcase
    end
  endtask

  task automatic gen_random(input int n, input bit e3);
    bit seen = 0;
    nsym = 0; gpol = 0;
    while (nsym < n) begin
      int r = $urandom % 100;
      if (r < 40) begin gpol = ~gpol; put(gpol, ~gpol); seen = 1; end
      else if (r < 58) put(0, 0);
      else if (r < 73 && seen) begin
        if ($urandom % 2) begin
          put(0, 0); put(0, 0); if (e3) put(0, 0);
        end else begin
          gpol = ~gpol; put(gpol, ~gpol); put(0, 0); if (e3) put(0, 0);
        end
        put(gpol, ~gpol);
      end
      else if (r < 80) begin put(gpol, ~gpol); seen = 1; end
      else if (r < 86) put(1, 1);
      else begin put(0, 0); put(0, 0); put(0, 0); put(0, 0); end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1, R9: first pulse after reset and strict alternation, no flags
    load("npnpnp0p");        run_seg("R1", 0, 0);
    load("pnpn0pn");         run_seg("R9", 1, 0);
    // R3: 00V and B0V in three-bit mode
    load("p00pnp0p0n0nn");   run_seg("R3", 0, 0);
    // R4: 000V and B00V in four-bit mode
    load("p000pnp00p0n");    run_seg("R4", 1, 0);
    // R5: lone violations, also a B0V shape in four-bit mode
    load("ppn0npnn0pn");     run_seg("R5", 0, 0);
    load("pn0np");           run_seg("R5", 1, 0);
    // R6: zero runs at both thresholds
    load("p000000n00p");     run_seg("R6", 0, 0);
    load("p0000000n000p");   run_seg("R6", 1, 0);
    // R7: both-rail samples, polarity kept, counted as zero
    load("pdpnd0ndpd0n");    run_seg("R7", 0, 0);
    // R8: bypass leaves everything as AMI
    load("pp00p000pdn0000n"); run_seg("R8", 0, 1);
    // R2 and mixed: constrained random streams
    for (int s = 0; s < 3; s++) begin
      gen_random(380, 0); run_seg("R2_R3", 0, 0);
      gen_random(380, 1); run_seg("R2_R4", 1, 0);
    end
    gen_random(380, 0); run_seg("R8", 0, 1);
    gen_random(380, 1); run_seg("R8", 1, 1);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog run did not finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule